// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is an up-counter that runs freely from the bus clock. A power-of-two prescaler sits in front of it and sets the count rate. Software starts the counter by setting a run bit. It picks a divide ratio of 2^N with a three-bit select field. The counter counts up without stopping and wraps from its all-ones value back to zero. Every wrap sets a sticky overflow flag. When the overflow interrupt enable bit is set, that flag drives the interrupt request.

The count is wider than the data port, so it is read as two halves. Reading the upper half copies the lower half of the same count into a holding register. A following read of the lower half therefore gives a consistent snapshot, even though the counter keeps moving. Software clears the flag by writing 1 to it. Any write to the prescale register restarts the divider, so the first step after the write takes a full new period.

Top module: `ftc_timer`

## Requirements
- R1: After reset the count, the run bit, the interrupt enable, the prescale select, the overflow flag and the held lower half are all zero, and irq is 0.
- R2: While the run bit (control register, address 0, bit 0) is 0, the count does not change.
- R3: With the run bit set and select 0, the count rises by one on every clock.
- R4: With select N (prescale register, address 1, bits 2:0), the count rises by one every 2^N clocks. The first step comes 2^N clocks after the clock edge at which the run bit takes effect.
- R5: After the all-ones value the count goes to zero and keeps counting.
- R6: The step from all-ones to zero sets the overflow flag (status register, address 2, bit 0), and the flag stays set.
- R7: Writing 1 to status bit 0 clears the flag, and writing 0 leaves it unchanged. If a wrap and a clearing write fall on the same edge, the flag stays set.
- R8: irq is 1 exactly when the overflow flag and the interrupt enable bit (address 0, bit 1) are both 1.
- R9: A read of address 3 returns the upper half of the count and, in the same cycle, captures the lower half. A read of address 4 returns that captured value.
- R10: A write to the prescale register restarts the divider. The next step then comes 2^N clocks after that write's edge.
- R11: Registers read back their written fields, zero-extended. Unmapped addresses read as zero. rdata is combinational from addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (captures the lower half on address 3) |
| addr | input | 3 | Register address |
| wdata | input | CNT_W/2 | Write data |
| rdata | output | CNT_W/2 | Read data for addr |
| irq | output | 1 | Overflow interrupt request |

## Verification
The embedded properties check every cycle that the count only holds or steps by one, that it holds while stopped, and that a step at the top reaches zero and sets the flag. They also check that the flag only drops on a clearing write, that the divider never ticks twice in a row for select values above zero, and that a read of the upper half captures the lower half. Only the bench scenarios show the exact step period and wrap cycle for each of the eight select values. The same goes for the phase reset caused by a prescale write, the case where a wrap and a clear land on the same edge, and the gating of irq by the enable bit. The bench compares these against a model that counts bus clocks.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int unsigned REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_PRESC  = 3'd1,
        REG_STAT   = 3'd2,
        REG_CNT_HI = 3'd3,
        REG_CNT_LO = 3'd4
    } ftc_reg_e;

    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_IE_BIT  = 1;
    localparam int unsigned STAT_OVF_BIT = 0;
endpackage

// File: rtl/ftc_prescaler.sv
module ftc_prescaler #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_d, div_q, mask;
    logic [DIV_W:0]   one_hot;

    always_comb begin
        one_hot = (DIV_W+1)'(1) << sel_i;
        mask    = DIV_W'(one_hot - 1'b1);
        tick_o  = en_i && !restart_i && (div_q == mask);
        if (!en_i || restart_i || tick_o) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel_i != '0) |=> !tick_o);
endmodule

// File: rtl/ftc_counter.sv
module ftc_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = tick_i ? cnt_q + ONE : cnt_q;
        wrap_o = tick_i && (cnt_q == '1);
        cnt_o  = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/ftc_timer.sv
module ftc_timer
    import ftc_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SEL_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [CNT_W/2-1:0]    wdata,
    output logic [CNT_W/2-1:0]    rdata,
    output logic                  irq
);
    localparam int unsigned DATA_W = CNT_W / 2;
    localparam int unsigned HALF   = DATA_W;

    typedef struct packed {
        logic             run;
        logic             ie;
        logic [SEL_W-1:0] sel;
        logic             ovf;
        logic [HALF-1:0]  lo;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tick_w, wrap_w;
    logic [CNT_W-1:0] cnt_w;
    logic             wr_ctrl, wr_presc, wr_stat, rd_hi, clr_req;
    logic             unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:SEL_W];

    ftc_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (r_q.run),
        .restart_i(wr_presc),
        .sel_i    (r_q.sel),
        .tick_o   (tick_w)
    );

    ftc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_w),
        .cnt_o (cnt_w),
        .wrap_o(wrap_w)
    );

    always_comb begin
        wr_ctrl  = wr_en && (addr == REG_CTRL);
        wr_presc = wr_en && (addr == REG_PRESC);
        wr_stat  = wr_en && (addr == REG_STAT);
        rd_hi    = rd_en && (addr == REG_CNT_HI);
        clr_req  = wr_stat && wdata[STAT_OVF_BIT];

        r_d = r_q;
        if (wr_ctrl) begin
            r_d.run = wdata[CTRL_RUN_BIT];
            r_d.ie  = wdata[CTRL_IE_BIT];
        end
        if (wr_presc) begin
            r_d.sel = wdata[SEL_W-1:0];
        end
        if (wrap_w) begin
            r_d.ovf = 1'b1;
        end else if (clr_req) begin
            r_d.ovf = 1'b0;
        end
        if (rd_hi) begin
            r_d.lo = cnt_w[HALF-1:0];
        end

        irq = r_q.ovf && r_q.ie;

        case (ftc_reg_e'(addr))
            REG_CTRL:   rdata = DATA_W'({r_q.ie, r_q.run});
            REG_PRESC:  rdata = DATA_W'(r_q.sel);
            REG_STAT:   rdata = DATA_W'(r_q.ovf);
            REG_CNT_HI: rdata = cnt_w[CNT_W-1:HALF];
            REG_CNT_LO: rdata = r_q.lo;
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.run |=> $stable(cnt_w));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_w |=> r_q.ovf);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ovf && !clr_req) |=> r_q.ovf);

    // R9
    lo_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (r_q.lo == $past(cnt_w[HALF-1:0])));
endmodule

// File: tb/ftc_timer_tb.sv
module ftc_timer_tb;
    localparam int CNT_W = 8;
    localparam int DW    = CNT_W / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int base = 0;
    bit done = 0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    ftc_timer #(.CNT_W(CNT_W), .SEL_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the scoreboard on every read strobe
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %0h expected none", rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s addr %0d: actual %0h expected %0h", t, addr, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [DW-1:0] e, input string t);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", t, act, e);
        end
    endtask

    function automatic logic [7:0] exp_cnt(input int kk, input int s);
        return 8'((kk >> s) & 255);
    endfunction

    task automatic rd_cnt(input int s, input string t);
        logic [7:0] e;
        e = exp_cnt(cyc - base, s);
        rd(3'd3, e[7:4], t);
        rd(3'd4, e[3:0], t);
    endtask

    task automatic idle_to(input int target);
        if (cyc - base < target) begin
            repeat (target - (cyc - base)) @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic enable(input logic [DW-1:0] ctrl);
        wr(3'd0, ctrl);
        base = cyc;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk_bit(irq, 1'b0, "R1 irq");
        rd(3'd0, 0, "R1 ctrl");
        rd(3'd1, 0, "R1 presc");
        rd(3'd2, 0, "R1 stat");
        rd(3'd3, 0, "R1 cnt hi");
        rd(3'd4, 0, "R1 cnt lo");

        // R11 readback and unmapped address
        wr(3'd1, 4'd5);
        rd(3'd1, 4'd5, "R11 presc");
        wr(3'd0, 4'd2);
        rd(3'd0, 4'd2, "R11 ctrl");
        rd(3'd7, 4'd0, "R11 unmapped");
        rd(3'd3, 4'd0, "R2 stopped hi");

        // R3 single-step counting, R9 capture, R2 hold after stop
        do_reset();
        wr(3'd1, 4'd0);
        enable(4'd1);
        idle_to(4);
        rd(3'd3, 4'd0, "R3 hi at 4");
        rd(3'd4, 4'd4, "R9 lo captured at 4");
        idle_to(9);
        wr(3'd0, 4'd0);
        repeat (20) @(posedge clk); #1;
        rd(3'd3, 4'd0, "R2 hold hi");
        rd(3'd4, 4'hA, "R2 hold lo");

        // R4 R5 R6 R8 wrap per select value
        for (int s = 0; s < 8; s++) begin
            logic ie;
            int per;
            ie  = (s % 2 == 0);
            per = 1 << s;
            do_reset();
            wr(3'd1, 4'(s));
            enable(ie ? 4'd3 : 4'd1);
            idle_to(per - 1);
            rd_cnt(s, "R4 before first step");
            idle_to(per + 1);
            rd_cnt(s, "R4 after first step");
            idle_to(256 * per - 2);
            chk_bit(irq, 1'b0, "R6 no flag before wrap");
            rd_cnt(s, "R5 top value");
            chk_bit(irq, ie, "R8 irq after wrap");
            rd(3'd2, 4'd1, "R6 flag set on wrap");
            rd_cnt(s, "R5 count after wrap");
            repeat (3) @(posedge clk); #1;
            rd(3'd2, 4'd1, "R6 flag sticky");
            if (!ie) begin
                wr(3'd0, 4'd3);
                chk_bit(irq, 1'b1, "R8 enable raises irq");
            end
            wr(3'd2, 4'd0);
            rd(3'd2, 4'd1, "R7 write 0 ignored");
            wr(3'd2, 4'd1);
            rd(3'd2, 4'd0, "R7 write 1 clears");
            chk_bit(irq, 1'b0, "R7 irq drops");
        end

        // R7 wrap and clear on the same edge
        do_reset();
        wr(3'd1, 4'd0);
        enable(4'd3);
        idle_to(255);
        wr(3'd2, 4'd1);
        rd(3'd2, 4'd1, "R7 set beats clear");
        chk_bit(irq, 1'b1, "R7 irq kept");

        // R10 prescale write restarts the divider
        do_reset();
        wr(3'd1, 4'd2);
        enable(4'd1);
        idle_to(2);
        wr(3'd1, 4'd2);
        rd(3'd3, 4'd0, "R10 hi at 3");
        rd(3'd4, 4'd0, "R10 lo at 3");
        rd(3'd3, 4'd0, "R10 hi at 5");
        rd(3'd4, 4'd0, "R10 no step at 5");
        rd(3'd3, 4'd0, "R10 hi at 7");
        rd(3'd4, 4'd1, "R10 step at 7");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule